// File: doc/BRIEF.md
# Privileged-Sequence Length Predictor

This block guesses how long the next stretch of privileged-mode execution will run, so that a migration controller can decide, in a single cycle, whether to move that stretch onto a dedicated core. When the processor enters privileged mode, the caller presents five 64-bit architected register values. The block folds them together with XOR and uses the low bits of the result as the index into a tag-less, direct-mapped history table. One cycle later it returns a predicted length, the table index it used, and a one-bit move decision that compares the prediction against a threshold supplied by software.

Each table slot keeps the length measured the last time its index was seen, together with a 2-bit trust counter. A slot whose trust is zero is not believed. In that case the block answers with the mean of the three most recently measured lengths, whatever slots they came from. When a privileged stretch ends, the caller returns the index it was given at lookup time together with the measured length. The block then rewrites that slot, moves its trust up or down according to a 5% closeness test, and pushes the length into the three-deep recent history. Because the index travels with the result, a new lookup may be issued before the previous stretch has been trained.

Top module: `runlen_predictor`

## Requirements
- R1: The table index is the low log2(table depth) bits of the XOR of `state_reg`, `glob_a`, `glob_b`, `arg_a` and `arg_b`. It is returned on `pred_idx` with the prediction.
- R2: Every cycle with `lookup_valid` high yields `pred_valid` high for exactly one cycle on the next cycle. `pred_valid` is low in every other cycle.
- R3: After reset every slot holds length 0 and trust 0, and the recent history holds three zeros. The first lookup therefore returns length 0.
- R4: Training always replaces the slot's stored length with `train_len`, whatever the slot's trust.
- R5: If the slot's stored length p and the measured length a satisfy |p − a| × 20 ≤ a, the trust counter rises by one and saturates at 3.
- R6: If the test of R5 fails, the trust counter falls by one and saturates at 0.
- R7: When the indexed slot has nonzero trust, `pred_len` is that slot's stored length.
- R8: When the indexed slot has zero trust, `pred_len` is floor((h0 + h1 + h2) / 3), where h0..h2 are the three most recently trained lengths from any slots.
- R9: `pred_offload` is 1 exactly when `pred_len` is strictly greater than the `threshold` sampled in the lookup cycle.
- R10: If a lookup and a training operation happen in the same cycle, the lookup sees the table and history as they were before that training operation, including when both use the same index.
- R11: Training writes the slot named by `train_idx`, which may differ from the index of any lookup issued in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_valid | input | 1 | Entry into privileged mode; perform a lookup |
| state_reg | input | DATA_W | Processor state register value |
| glob_a | input | DATA_W | First global register value |
| glob_b | input | DATA_W | Second global register value |
| arg_a | input | DATA_W | First input-argument register value |
| arg_b | input | DATA_W | Second input-argument register value |
| threshold | input | LEN_W | Move threshold N |
| train_valid | input | 1 | A privileged stretch ended; train |
| train_idx | input | IDX_W | Index returned by the matching lookup |
| train_len | input | LEN_W | Measured length of the stretch |
| pred_valid | output | 1 | Prediction outputs valid this cycle |
| pred_idx | output | IDX_W | Table index used by the lookup |
| pred_len | output | LEN_W | Predicted length |
| pred_offload | output | 1 | Predicted length exceeds threshold |

## Verification
The hardest case to reach from the ports is a slot whose trust is nonzero but whose neighbours in the recent history disagree with it. Only then do the local and global paths give different answers, and the trust counter only rises after repeated trainings that land within 5% of each other. The stimulus trains one slot several times with lengths chosen to sit exactly on and just beyond the 5% boundary. It then interleaves trainings of other slots, so that the recent-history mean drifts away from the slot's stored value. A long mixed run follows that issues lookups and trainings together, often to the same index in the same cycle, so that the pre-update rule is exercised many times.

// File: rtl/rlp_pkg.sv
package rlp_pkg;

  typedef logic [1:0] conf_t;

  localparam conf_t CONF_TOP = 2'd3;
  localparam conf_t CONF_BOT = 2'd0;

  // Saturating trust update: up on a close call, down otherwise.
  function automatic conf_t conf_step(input conf_t c, input logic close);
    if (close) return (c == CONF_TOP) ? c : conf_t'(c + 2'd1);
    else       return (c == CONF_BOT) ? c : conf_t'(c - 2'd1);
  endfunction

endpackage

// File: rtl/rlp_hash.sv
module rlp_hash #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = 4
) (
  input  logic [DATA_W-1:0] v0,
  input  logic [DATA_W-1:0] v1,
  input  logic [DATA_W-1:0] v2,
  input  logic [DATA_W-1:0] v3,
  input  logic [DATA_W-1:0] v4,
  output logic [IDX_W-1:0]  idx
);

  function automatic logic [DATA_W-1:0] fold5(
    input logic [DATA_W-1:0] a, b, c, d, e);
    return a ^ b ^ c ^ d ^ e;
  endfunction

  logic [DATA_W-1:0] folded;

  assign folded = fold5(v0, v1, v2, v3, v4);
  assign idx    = folded[IDX_W-1:0];

endmodule

// File: rtl/rlp_table.sv
module rlp_table
  import rlp_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int IDX_W = 4,
  localparam int SLOTS = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [LEN_W-1:0] rd_len,
  output conf_t            rd_conf,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [LEN_W-1:0] wr_len,
  output logic             wr_close
);

  localparam int WIDE_W = LEN_W + 5;

  // |p - a| * 20 <= a, in arithmetic wide enough to hold 20x the largest length.
  function automatic logic is_close(input logic [LEN_W-1:0] p, input logic [LEN_W-1:0] a);
    logic [LEN_W-1:0]  d;
    logic [WIDE_W-1:0] dw, d20, aw;
    d   = (p > a) ? (p - a) : (a - p);
    dw  = {5'd0, d};
    d20 = (dw << 4) + (dw << 2);
    aw  = {5'd0, a};
    return d20 <= aw;
  endfunction

  logic [SLOTS-1:0][LEN_W-1:0] len_all;
  conf_t [SLOTS-1:0]           conf_all;
  conf_t                       conf_next;

  assign wr_close  = is_close(len_all[wr_idx], wr_len);
  assign conf_next = conf_step(conf_all[wr_idx], wr_close);
  assign rd_len    = len_all[rd_idx];
  assign rd_conf   = conf_all[rd_idx];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [LEN_W-1:0] len_r;
    conf_t            conf_r;
    logic             sel;

    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        len_r  <= '0;
        conf_r <= CONF_BOT;
      end else if (sel) begin
        len_r  <= wr_len;
        conf_r <= conf_next;
      end
    end

    assign len_all[g]  = len_r;
    assign conf_all[g] = conf_r;
  end

  // R4: the measured length always lands in the slot
  assert_len_overwrite_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> len_all[$past(wr_idx)] == $past(wr_len));

  // R5: close call raises trust by one
  assert_conf_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_close && conf_all[wr_idx] != CONF_TOP)
      |=> conf_all[$past(wr_idx)] == conf_t'($past(conf_all[wr_idx]) + 2'd1));

  // R5: trust saturates at the top
  assert_conf_sat_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_close && conf_all[wr_idx] == CONF_TOP)
      |=> conf_all[$past(wr_idx)] == CONF_TOP);

  // R6: a miss never raises trust, and trust stays at zero when already zero
  assert_conf_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_close)
      |=> conf_all[$past(wr_idx)] <= $past(conf_all[wr_idx]) &&
          ($past(conf_all[wr_idx]) == CONF_BOT || conf_all[$past(wr_idx)] != $past(conf_all[wr_idx])));

endmodule

// File: rtl/rlp_history.sv
module rlp_history #(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LEN_W-1:0] push_len,
  output logic [LEN_W-1:0] mean3
);

  localparam int SUM_W  = LEN_W + 2;
  localparam int SHIFT  = SUM_W + 1;
  localparam int PROD_W = SUM_W + SHIFT;
  // ceil(2^SHIFT / 3): exact floor(x/3) for every x below 2^SUM_W
  localparam logic [SHIFT-1:0] MAGIC = SHIFT'(((64'd1 << SHIFT) + 64'd2) / 64'd3);

  function automatic logic [LEN_W-1:0] div3(input logic [SUM_W-1:0] x);
    logic [PROD_W-1:0] p;
    p = {{SHIFT{1'b0}}, x} * {{SUM_W{1'b0}}, MAGIC};
    return p[SHIFT +: LEN_W];
  endfunction

  logic [LEN_W-1:0] h0, h1, h2;
  logic [SUM_W-1:0] sum3;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h0 <= '0;
      h1 <= '0;
      h2 <= '0;
    end else if (push) begin
      h0 <= push_len;
      h1 <= h0;
      h2 <= h1;
    end
  end

  assign sum3  = SUM_W'(h0) + SUM_W'(h1) + SUM_W'(h2);
  assign mean3 = div3(sum3);

  // R8: history shifts newest-first on each training
  assert_hist_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (h0 == $past(push_len)) && (h1 == $past(h0)) && (h2 == $past(h1)));

  // R8: the multiply-shift quotient is the floor of the sum over three
  assert_mean_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((SUM_W + 2)'(mean3) * 3 <= (SUM_W + 2)'(sum3)) &&
    ((SUM_W + 2)'(sum3) < (SUM_W + 2)'(mean3) * 3 + 3));

endmodule

// File: rtl/runlen_predictor.sv
module runlen_predictor
  import rlp_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int LEN_W  = 24,
  parameter int DEPTH  = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookup_valid,
  input  logic [DATA_W-1:0] state_reg,
  input  logic [DATA_W-1:0] glob_a,
  input  logic [DATA_W-1:0] glob_b,
  input  logic [DATA_W-1:0] arg_a,
  input  logic [DATA_W-1:0] arg_b,
  input  logic [LEN_W-1:0]  threshold,
  input  logic              train_valid,
  input  logic [IDX_W-1:0]  train_idx,
  input  logic [LEN_W-1:0]  train_len,
  output logic              pred_valid,
  output logic [IDX_W-1:0]  pred_idx,
  output logic [LEN_W-1:0]  pred_len,
  output logic              pred_offload
);

  logic [IDX_W-1:0] look_idx;
  logic [LEN_W-1:0] slot_len;
  conf_t            slot_conf;
  logic [LEN_W-1:0] recent_mean;
  logic             train_close;
  logic             use_global;
  logic [LEN_W-1:0] chosen_len;
  logic             chosen_move;

  rlp_hash #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_hash (
    .v0(state_reg), .v1(glob_a), .v2(glob_b), .v3(arg_a), .v4(arg_b),
    .idx(look_idx)
  );

  rlp_table #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(look_idx), .rd_len(slot_len), .rd_conf(slot_conf),
    .wr_en(train_valid), .wr_idx(train_idx), .wr_len(train_len),
    .wr_close(train_close)
  );

  rlp_history #(.LEN_W(LEN_W)) u_hist (
    .clk(clk), .rst_n(rst_n),
    .push(train_valid), .push_len(train_len),
    .mean3(recent_mean)
  );

  // Reads use pre-edge state, so a same-cycle training is not yet visible.
  assign use_global  = (slot_conf == CONF_BOT);
  assign chosen_len  = use_global ? recent_mean : slot_len;
  assign chosen_move = chosen_len > threshold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_valid   <= 1'b0;
      pred_idx     <= '0;
      pred_len     <= '0;
      pred_offload <= 1'b0;
    end else begin
      pred_valid <= lookup_valid;
      if (lookup_valid) begin
        pred_idx     <= look_idx;
        pred_len     <= chosen_len;
        pred_offload <= chosen_move;
      end
    end
  end

  // R2: a lookup yields a one-cycle valid on the next cycle
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> pred_valid);

  assert_valid_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |=> !pred_valid);

  // R9: strict comparison against the threshold of the lookup cycle
  assert_offload_strict_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> pred_offload == (pred_len > $past(threshold)));

  // R7: a trusted slot is returned as stored
  assert_local_pick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && slot_conf != CONF_BOT) |=> pred_len == $past(slot_len));

  // R8: an untrusted slot falls back to the recent mean
  assert_global_pick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_valid && slot_conf == CONF_BOT) |=> pred_len == $past(recent_mean));

endmodule

// File: tb/runlen_predictor_test.sv
module runlen_predictor_test;

  localparam int DATA_W = 64;
  localparam int LEN_W  = 24;
  localparam int DEPTH  = 16;
  localparam int IDX_W  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              lookup_valid = 1'b0;
  logic [DATA_W-1:0] state_reg = '0, glob_a = '0, glob_b = '0, arg_a = '0, arg_b = '0;
  logic [LEN_W-1:0]  threshold = '0;
  logic              train_valid = 1'b0;
  logic [IDX_W-1:0]  train_idx = '0;
  logic [LEN_W-1:0]  train_len = '0;
  logic              pred_valid;
  logic [IDX_W-1:0]  pred_idx;
  logic [LEN_W-1:0]  pred_len;
  logic              pred_offload;

  always #5 clk = ~clk;

  runlen_predictor #(.DATA_W(DATA_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid),
    .state_reg(state_reg), .glob_a(glob_a), .glob_b(glob_b),
    .arg_a(arg_a), .arg_b(arg_b), .threshold(threshold),
    .train_valid(train_valid), .train_idx(train_idx), .train_len(train_len),
    .pred_valid(pred_valid), .pred_idx(pred_idx), .pred_len(pred_len),
    .pred_offload(pred_offload)
  );

  int checks = 0;
  int failures = 0;
  bit monitor_on = 1'b0;

  // Reference state built from the requirements
  longint m_len[DEPTH];
  int     m_conf[DEPTH];
  longint m_hist[3];

  // Scoreboard queues
  longint q_len[$];
  bit     q_off[$];
  int     q_idx[$];
  string  q_tag[$];

  function automatic void model_reset();
    for (int i = 0; i < DEPTH; i++) begin
      m_len[i]  = 0;
      m_conf[i] = 0;
    end
    for (int i = 0; i < 3; i++) m_hist[i] = 0;
  endfunction

  // R5 / R6 / R4 / R8 reference update
  function automatic void model_train(int idx, longint a);
    longint d;
    d = (m_len[idx] > a) ? m_len[idx] - a : a - m_len[idx];
    if (d * 20 <= a) m_conf[idx] = (m_conf[idx] == 3) ? 3 : m_conf[idx] + 1;
    else             m_conf[idx] = (m_conf[idx] == 0) ? 0 : m_conf[idx] - 1;
    m_len[idx] = a;
    m_hist[2] = m_hist[1];
    m_hist[1] = m_hist[0];
    m_hist[0] = a;
  endfunction

  function automatic void expect_push(int idx, longint thr, string tag);
    longint p;
    string  t;
    if (m_conf[idx] == 0) begin
      p = (m_hist[0] + m_hist[1] + m_hist[2]) / 3;
      t = "R8";
    end else begin
      p = m_len[idx];
      t = "R7";
    end
    if (tag != "") t = tag;
    q_len.push_back(p);
    q_off.push_back(p > thr);
    q_idx.push_back(idx);
    q_tag.push_back(t);
  endfunction

  // One cycle of stimulus; called 1 time unit after a falling edge.
  task automatic op(input bit do_lk, input logic [DATA_W-1:0] r0, r1, r2, r3, r4,
                    input longint thr, input bit do_tr, input int tidx,
                    input longint tlen, input string tag);
    if (do_lk) begin
      int idx;
      idx = int'((r0 ^ r1 ^ r2 ^ r3 ^ r4) & DATA_W'(DEPTH - 1));
      expect_push(idx, thr, tag);
      lookup_valid = 1'b1;
      state_reg = r0; glob_a = r1; glob_b = r2; arg_a = r3; arg_b = r4;
      threshold = LEN_W'(thr);
    end
    if (do_tr) begin
      model_train(tidx, tlen);
      train_valid = 1'b1;
      train_idx   = IDX_W'(tidx);
      train_len   = LEN_W'(tlen);
    end
    @(negedge clk);
    #1;
    lookup_valid = 1'b0;
    train_valid  = 1'b0;
  endtask

  // Lookup at a chosen index: paired registers cancel, the state register sets the index.
  task automatic lk(input int idx, input longint thr, input string tag);
    op(1'b1, {48'hC0DE_5EED_0000, 16'(idx)}, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0,
       64'h0F0F_F0F0_3C3C_C3C3, 64'h0F0F_F0F0_3C3C_C3C3, thr, 1'b0, 0, 0, tag);
  endtask

  task automatic tr(input int idx, input longint len);
    op(1'b0, '0, '0, '0, '0, '0, 0, 1'b1, idx, len, "");
  endtask

  task automatic lk_tr(input int lidx, input longint thr, input int tidx, input longint len,
                       input string tag);
    op(1'b1, {48'hC0DE_5EED_0000, 16'(lidx)}, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0,
       64'h0F0F_F0F0_3C3C_C3C3, 64'h0F0F_F0F0_3C3C_C3C3, thr, 1'b1, tidx, len, tag);
  endtask

  task automatic idle();
    op(1'b0, '0, '0, '0, '0, '0, 0, 1'b0, 0, 0, "");
  endtask

  // Monitor: pops one expected item on each falling edge that follows a lookup.
  initial begin
    forever begin
      @(negedge clk);
      if (monitor_on) begin
        if (pred_valid) begin
          if (q_len.size() == 0) begin
            checks++; failures++;
            $display("FAIL R2: pred_valid=1 with no pending lookup (actual 1, expected 0)");
          end else begin
            longint el;
            bit     eo;
            int     ei;
            string  et;
            el = q_len.pop_front(); eo = q_off.pop_front();
            ei = q_idx.pop_front(); et = q_tag.pop_front();
            checks++;
            if (longint'(pred_len) != el) begin
              failures++;
              $display("FAIL %s: pred_len actual %0d expected %0d", et, pred_len, el);
            end
            checks++;
            if (pred_offload != eo) begin
              failures++;
              $display("FAIL R9 (%s): pred_offload actual %0d expected %0d (len %0d)",
                       et, pred_offload, eo, el);
            end
            checks++;
            if (int'(pred_idx) != ei) begin
              failures++;
              $display("FAIL R1: pred_idx actual %0d expected %0d", pred_idx, ei);
            end
          end
        end else if (q_len.size() != 0) begin
          checks++; failures++;
          $display("FAIL R2: pred_valid actual 0 expected 1");
          void'(q_len.pop_front()); void'(q_off.pop_front());
          void'(q_idx.pop_front()); void'(q_tag.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish (actual timeout, expected completion)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R3: reset state at the outputs
    checks++;
    if (pred_valid !== 1'b0 || pred_len !== '0 || pred_offload !== 1'b0) begin
      failures++;
      $display("FAIL R3: outputs after reset actual v=%0d len=%0d off=%0d expected 0 0 0",
               pred_valid, pred_len, pred_offload);
    end
    monitor_on = 1'b1;

    // R3: first lookup sees zero slot and zero history -> 0, not above threshold 0
    lk(7, 0, "R3");

    // R1: five distinct values; index = low 4 bits of their XOR (= 0xB here)
    op(1'b1, 64'hFFFF_0000_1111_2223, 64'h0000_0000_0000_0010, 64'h8000_0000_0000_0100,
       64'h0000_0000_0000_1008, 64'h0000_ABCD_0000_0000, 5, 1'b0, 0, 0, "R1");

    // R6: train slot 5 with 100 from 0 -> miss, trust stays 0; history = 100,0,0
    tr(5, 100);
    // R8: fallback mean = 33; threshold 33 is not exceeded (R9 strict), 32 is
    lk(5, 33, "R8");
    lk(5, 32, "R9");

    // R5: 105 vs stored 100: |5|*20 = 100 <= 105 -> trust 1; R7 then returns 105
    tr(5, 105);
    lk(5, 104, "R7");

    // R6 boundary: stored 105, actual 100: 5*20 = 100 <= 100 -> still close, trust 2
    tr(5, 100);
    // Just beyond: stored 100, actual 95: 5*20 = 100 > 95 -> miss, trust 1
    tr(5, 95);
    lk(5, 0, "R6");
    // Two more close hits to 3, then a third to test saturation
    tr(5, 95);
    tr(5, 95);
    tr(5, 95);
    // R4 and R6: large miss from trust 3 -> trust 2, stored length becomes 400
    tr(5, 400);
    // Other slots move the recent mean away from slot 5
    tr(2, 9);
    tr(3, 9);
    lk(5, 399, "R4");
    // Misses drop trust 2 -> 1 -> 0; then the mean is used
    tr(5, 10);
    tr(5, 500);
    lk(5, 0, "R6");
    lk(2, 100, "R8");

    // R11: lookup slot 9, unrelated training of slot 12, then training with carried index 9
    lk(9, 0, "R11");
    tr(12, 60);
    tr(9, 60);
    tr(9, 61);
    lk(9, 60, "R11");

    // R10: same-cycle lookup and training of the same slot sees pre-update values
    lk_tr(9, 0, 9, 1000, "R10");
    lk(9, 999, "R10");
    lk_tr(1, 10, 1, 50, "R10");
    lk_tr(1, 10, 4, 70, "R10");

    // R2: back-to-back lookups each produce their own one-cycle result
    lk(9, 0, "R2");
    lk(12, 0, "R2");
    idle();
    idle();

    // Mixed run: many slots, close and far lengths, lookups and trainings together
    for (int i = 0; i < 600; i++) begin
      int     li, ti;
      bit     dl, dt;
      longint len, thr;
      li  = int'($urandom_range(DEPTH - 1, 0));
      ti  = ($urandom_range(3, 0) == 0) ? li : int'($urandom_range(DEPTH - 1, 0));
      dl  = $urandom_range(1, 0) == 1;
      dt  = $urandom_range(2, 0) != 0;
      len = ($urandom_range(4, 0) == 0) ? longint'($urandom_range(5000, 0))
                                        : longint'($urandom_range(110, 90));
      thr = longint'($urandom_range(120, 80));
      op(dl, {48'hAAAA_0000_0000, 16'(li)}, 64'h77, 64'h77, 64'h3, 64'h3,
         thr, dt, ti, len, (dl && dt && li == ti) ? "R10" : "");
    end

    idle();
    idle();
    checks++;
    if (q_len.size() != 0) begin
      failures++;
      $display("FAIL R2: pending results actual %0d expected 0", q_len.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule